// File: doc/BRIEF.md
# Tagged-Token Operand Matching Unit

This block is the firing logic of one two-operand node in a dynamic dataflow fabric. Operand tokens arrive on two independent input channels, called left and right. Each token carries a data word and an instance tag, and each channel uses a valid/ready handshake. A token that finds no partner waits in a small per-channel associative store, so several instances of the computation can wait on the same edge at the same time.

Every cycle, the unit searches both stores for a left entry and a right entry that carry equal tags. When it finds such a pair and the output register can take a result, it removes both entries. It then emits one result token that keeps the shared tag and carries the sum of the two data words. Pairing follows tags, not arrival order, so instances complete in whatever order their operands become available.

A static-mode input limits each edge to one outstanding token. In that mode a second token on an occupied edge is held off by back-pressure.

Top module: `tag_match_unit`

## Requirements
- R1: A result token is produced only from one left token and one right token with equal tags. It carries that tag, and its data is (left data + right data) modulo 2^DATA_W.
- R2: Tokens whose tags differ are never combined. They stay waiting and remain available to a later partner with a matching tag.
- R3: Each channel holds up to DEPTH (default 8) waiting tokens. While DEPTH tokens wait on a channel, that channel's ready is low and an offered token is not taken. Ready returns high after a firing frees an entry of that channel.
- R4: While static_mode is 1, a channel's ready is high only when its store is empty, so each edge holds at most one token.
- R5: An instance whose two operands are both present fires even when older, unmatched tokens of other instances are waiting.
- R6: When several pairs can fire, the pair whose left token was accepted earliest fires first. Its partner is the earliest-accepted right token with the same tag.
- R7: While out_valid is 1 and out_ready is 0, out_valid, out_tag and out_data hold their values, and no token is lost or duplicated.
- R8: After reset, out_valid is 0, both stores are empty, and both ready outputs are 1 when static_mode is 0.
- R9: Each firing removes exactly one entry from each store, and each accepted input adds exactly one entry to its channel's store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| static_mode | input | 1 | 1 limits each input edge to one waiting token |
| l_valid | input | 1 | Left token offered |
| l_tag | input | TAG_W | Left token instance tag |
| l_data | input | DATA_W | Left token data |
| l_ready | output | 1 | Left channel can accept a token |
| r_valid | input | 1 | Right token offered |
| r_tag | input | TAG_W | Right token instance tag |
| r_data | input | DATA_W | Right token data |
| r_ready | output | 1 | Right channel can accept a token |
| out_valid | output | 1 | Result token present |
| out_tag | output | TAG_W | Result token tag |
| out_data | output | DATA_W | Result token data |
| out_ready | input | 1 | Downstream takes the result token |

## Verification
A corrupt tag or valid bit in a store entry shows up at the ports in one of three ways. A result appears with a wrong tag or sum, a pair that should fire never appears, or a token appears twice. Each of these is visible within a few cycles of the partner token's arrival. A wrong age rank reverses the order of results whenever several pairs are pending behind a stalled output. A wrong occupancy count shows as a ready that drops too early, or one that stays high past DEPTH waiting tokens, on the very next cycle.

// File: rtl/tmu_pkg.sv
package tmu_pkg;

  localparam int unsigned TMU_DEPTH_DEF  = 8;
  localparam int unsigned TMU_TAG_W_DEF  = 4;
  localparam int unsigned TMU_DATA_W_DEF = 16;

  typedef enum logic {
    EDGE_DYNAMIC = 1'b0,
    EDGE_STATIC  = 1'b1
  } edge_mode_e;

endpackage

// File: rtl/tmu_token_store.sv
module tmu_token_store
  import tmu_pkg::*;
#(
  parameter int unsigned DEPTH  = TMU_DEPTH_DEF,
  parameter int unsigned TAG_W  = TMU_TAG_W_DEF,
  parameter int unsigned DATA_W = TMU_DATA_W_DEF,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  edge_mode_e                        mode,
  input  logic                              in_valid,
  input  logic [TAG_W-1:0]                  in_tag,
  input  logic [DATA_W-1:0]                 in_data,
  output logic                              in_ready,
  input  logic                              rm_en,
  input  logic [IDX_W-1:0]                  rm_idx,
  output logic [DEPTH-1:0]                  ent_valid,
  output logic [DEPTH-1:0][TAG_W-1:0]       ent_tag,
  output logic [DEPTH-1:0][DATA_W-1:0]      ent_data,
  output logic [DEPTH-1:0][IDX_W-1:0]       ent_rank
);

  logic [DEPTH-1:0]             valid_q, valid_n;
  logic [DEPTH-1:0][TAG_W-1:0]  tag_q, tag_n;
  logic [DEPTH-1:0][DATA_W-1:0] data_q, data_n;
  logic [DEPTH-1:0][IDX_W-1:0]  rank_q, rank_n;
  logic [CNT_W-1:0]             cnt;
  logic [IDX_W-1:0]             free_idx;
  logic                         wr_en;
  logic                         upd_en;

  assign cnt = CNT_W'($countones(valid_q));

  // lowest empty slot
  always_comb begin
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!valid_q[i]) free_idx = IDX_W'(i);
    end
  end

  assign in_ready = (mode == EDGE_STATIC) ? (cnt == '0) : (cnt != CNT_W'(DEPTH));
  assign wr_en    = in_valid & in_ready;
  assign upd_en   = wr_en | rm_en;

  // next state: removal compacts age ranks, insertion takes the youngest rank
  always_comb begin
    valid_n = valid_q;
    tag_n   = tag_q;
    data_n  = data_q;
    rank_n  = rank_q;
    if (rm_en) begin
      valid_n[rm_idx] = 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
        if (valid_q[i] && (rank_q[i] > rank_q[rm_idx])) begin
          rank_n[i] = rank_q[i] - 1'b1;
        end
      end
    end
    if (wr_en) begin
      valid_n[free_idx] = 1'b1;
      tag_n[free_idx]   = in_tag;
      data_n[free_idx]  = in_data;
      rank_n[free_idx]  = IDX_W'(cnt - {{(CNT_W-1){1'b0}}, rm_en});
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      rank_q  <= '0;
    end else if (upd_en) begin
      valid_q <= valid_n;
      rank_q  <= rank_n;
    end
  end

  always_ff @(posedge clk) begin
    if (upd_en) begin
      tag_q  <= tag_n;
      data_q <= data_n;
    end
  end

  assign ent_valid = valid_q;
  assign ent_tag   = tag_q;
  assign ent_data  = data_q;
  assign ent_rank  = rank_q;

  // R3: a token is only taken while a slot is free
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (cnt < CNT_W'(DEPTH)));

  // R9: occupancy moves by exactly the accepted and removed tokens
  a_r9_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cnt == CNT_W'($past(cnt) + CNT_W'($past(wr_en)) - CNT_W'($past(rm_en)))));

  // R9: only a waiting entry may be removed
  a_r9_remove_live: assert property (@(posedge clk) disable iff (!rst_n)
    rm_en |-> valid_q[rm_idx]);

  // R4: in static mode an edge never holds a second token
  a_r4_static_single: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == EDGE_STATIC) && ($past(mode) == EDGE_STATIC) && ($past(cnt) <= 1))
      |-> (cnt <= 1));

endmodule

// File: rtl/tmu_pair_select.sv
module tmu_pair_select #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned TAG_W = 4,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [DEPTH-1:0]            l_valid,
  input  logic [DEPTH-1:0][TAG_W-1:0] l_tag,
  input  logic [DEPTH-1:0][IDX_W-1:0] l_rank,
  input  logic [DEPTH-1:0]            r_valid,
  input  logic [DEPTH-1:0][TAG_W-1:0] r_tag,
  input  logic [DEPTH-1:0][IDX_W-1:0] r_rank,
  input  logic                        can_fire,
  output logic                        fire,
  output logic [IDX_W-1:0]            l_idx,
  output logic [IDX_W-1:0]            r_idx
);

  logic [DEPTH-1:0] l_hit;
  logic             l_found;
  logic [IDX_W-1:0] l_best;
  logic             r_found;
  logic [IDX_W-1:0] r_best;

  // left entries that have some right partner
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      l_hit[i] = 1'b0;
      for (int j = 0; j < DEPTH; j++) begin
        if (l_valid[i] && r_valid[j] && (l_tag[i] == r_tag[j])) l_hit[i] = 1'b1;
      end
    end
  end

  // oldest matchable left entry
  always_comb begin
    l_found = 1'b0;
    l_idx   = '0;
    l_best  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (l_hit[i] && (!l_found || (l_rank[i] < l_best))) begin
        l_found = 1'b1;
        l_idx   = IDX_W'(i);
        l_best  = l_rank[i];
      end
    end
  end

  // oldest right entry with the chosen tag
  always_comb begin
    r_found = 1'b0;
    r_idx   = '0;
    r_best  = '0;
    for (int j = 0; j < DEPTH; j++) begin
      if (r_valid[j] && (r_tag[j] == l_tag[l_idx]) && (!r_found || (r_rank[j] < r_best))) begin
        r_found = 1'b1;
        r_idx   = IDX_W'(j);
        r_best  = r_rank[j];
      end
    end
  end

  assign fire = l_found & r_found & can_fire;

  // checker: is any waiting pair older on either side than the one chosen
  logic older_l;
  logic older_r;
  always_comb begin
    older_l = 1'b0;
    older_r = 1'b0;
    for (int k = 0; k < DEPTH; k++) begin
      if (l_hit[k] && (l_rank[k] < l_rank[l_idx])) older_l = 1'b1;
      if (r_valid[k] && (r_tag[k] == l_tag[l_idx]) && (r_rank[k] < r_rank[r_idx])) older_r = 1'b1;
    end
  end

  // R1 R2: both chosen entries are live and carry the same tag
  a_r2_tags_equal: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (l_valid[l_idx] && r_valid[r_idx] && (l_tag[l_idx] == r_tag[r_idx])));

  // R6: no older candidate is passed over
  a_r6_oldest_first: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (!older_l && !older_r));

  // R5: a present pair fires whenever the output can take it
  a_r5_no_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (can_fire && (l_hit != '0)) |-> fire);

endmodule

// File: rtl/tmu_out_reg.sv
module tmu_out_reg #(
  parameter int unsigned TAG_W  = 4,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [TAG_W-1:0]  load_tag,
  input  logic [DATA_W-1:0] load_data,
  output logic              can_load,
  output logic              out_valid,
  output logic [TAG_W-1:0]  out_tag,
  output logic [DATA_W-1:0] out_data,
  input  logic              out_ready
);

  logic              vld_q, vld_n;
  logic [TAG_W-1:0]  tag_q;
  logic [DATA_W-1:0] data_q;

  assign can_load = ~vld_q | out_ready;
  assign vld_n    = load | (vld_q & ~out_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_n;
  end

  always_ff @(posedge clk) begin
    if (load) begin
      tag_q  <= load_tag;
      data_q <= load_data;
    end
  end

  assign out_valid = vld_q;
  assign out_tag   = tag_q;
  assign out_data  = data_q;

  // R7: a stalled result is held unchanged
  a_r7_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_tag) && $stable(out_data)));

  // R7: nothing is loaded over a result that has not been taken
  a_r7_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (!out_valid || out_ready));

endmodule

// File: rtl/tag_match_unit.sv
module tag_match_unit
  import tmu_pkg::*;
#(
  parameter int unsigned DEPTH  = TMU_DEPTH_DEF,
  parameter int unsigned TAG_W  = TMU_TAG_W_DEF,
  parameter int unsigned DATA_W = TMU_DATA_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              static_mode,
  input  logic              l_valid,
  input  logic [TAG_W-1:0]  l_tag,
  input  logic [DATA_W-1:0] l_data,
  output logic              l_ready,
  input  logic              r_valid,
  input  logic [TAG_W-1:0]  r_tag,
  input  logic [DATA_W-1:0] r_data,
  output logic              r_ready,
  output logic              out_valid,
  output logic [TAG_W-1:0]  out_tag,
  output logic [DATA_W-1:0] out_data,
  input  logic              out_ready
);

  localparam int unsigned NUM_IN = 2;
  localparam int unsigned IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  edge_mode_e                                   mode;
  logic [NUM_IN-1:0]                            in_vld;
  logic [NUM_IN-1:0][TAG_W-1:0]                 in_tag;
  logic [NUM_IN-1:0][DATA_W-1:0]                in_dat;
  logic [NUM_IN-1:0]                            in_rdy;
  logic [NUM_IN-1:0][IDX_W-1:0]                 rm_idx;
  logic [NUM_IN-1:0][DEPTH-1:0]                 st_valid;
  logic [NUM_IN-1:0][DEPTH-1:0][TAG_W-1:0]      st_tag;
  logic [NUM_IN-1:0][DEPTH-1:0][DATA_W-1:0]     st_data;
  logic [NUM_IN-1:0][DEPTH-1:0][IDX_W-1:0]      st_rank;
  logic                                         fire;
  logic                                         can_fire;
  logic [DATA_W-1:0]                            sum;

  assign mode      = static_mode ? EDGE_STATIC : EDGE_DYNAMIC;
  assign in_vld    = {r_valid, l_valid};
  assign in_tag[0] = l_tag;
  assign in_tag[1] = r_tag;
  assign in_dat[0] = l_data;
  assign in_dat[1] = r_data;
  assign l_ready   = in_rdy[0];
  assign r_ready   = in_rdy[1];

  for (genvar g = 0; g < NUM_IN; g++) begin : g_store
    tmu_token_store #(
      .DEPTH  (DEPTH),
      .TAG_W  (TAG_W),
      .DATA_W (DATA_W)
    ) i_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode      (mode),
      .in_valid  (in_vld[g]),
      .in_tag    (in_tag[g]),
      .in_data   (in_dat[g]),
      .in_ready  (in_rdy[g]),
      .rm_en     (fire),
      .rm_idx    (rm_idx[g]),
      .ent_valid (st_valid[g]),
      .ent_tag   (st_tag[g]),
      .ent_data  (st_data[g]),
      .ent_rank  (st_rank[g])
    );
  end

  tmu_pair_select #(
    .DEPTH (DEPTH),
    .TAG_W (TAG_W)
  ) i_select (
    .clk      (clk),
    .rst_n    (rst_n),
    .l_valid  (st_valid[0]),
    .l_tag    (st_tag[0]),
    .l_rank   (st_rank[0]),
    .r_valid  (st_valid[1]),
    .r_tag    (st_tag[1]),
    .r_rank   (st_rank[1]),
    .can_fire (can_fire),
    .fire     (fire),
    .l_idx    (rm_idx[0]),
    .r_idx    (rm_idx[1])
  );

  assign sum = st_data[0][rm_idx[0]] + st_data[1][rm_idx[1]];

  tmu_out_reg #(
    .TAG_W  (TAG_W),
    .DATA_W (DATA_W)
  ) i_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (fire),
    .load_tag  (st_tag[0][rm_idx[0]]),
    .load_data (sum),
    .can_load  (can_fire),
    .out_valid (out_valid),
    .out_tag   (out_tag),
    .out_data  (out_data),
    .out_ready (out_ready)
  );

  // R8: a result can only follow a firing in the previous cycle or a held result
  a_r8_out_from_fire: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(fire));

endmodule

// File: tb/test_tag_match_unit.sv
module test_tag_match_unit;

  localparam int TAG_W  = 4;
  localparam int DATA_W = 16;
  localparam int DEPTH  = 8;

  logic              clk;
  logic              rst_n;
  logic              static_mode;
  logic              l_valid;
  logic [TAG_W-1:0]  l_tag;
  logic [DATA_W-1:0] l_data;
  logic              l_ready;
  logic              r_valid;
  logic [TAG_W-1:0]  r_tag;
  logic [DATA_W-1:0] r_data;
  logic              r_ready;
  logic              out_valid;
  logic [TAG_W-1:0]  out_tag;
  logic [DATA_W-1:0] out_data;
  logic              out_ready;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  tag_match_unit #(.DEPTH(DEPTH), .TAG_W(TAG_W), .DATA_W(DATA_W)) i_tag_match_unit (
    .clk(clk), .rst_n(rst_n), .static_mode(static_mode),
    .l_valid(l_valid), .l_tag(l_tag), .l_data(l_data), .l_ready(l_ready),
    .r_valid(r_valid), .r_tag(r_tag), .r_data(r_data), .r_ready(r_ready),
    .out_valid(out_valid), .out_tag(out_tag), .out_data(out_data), .out_ready(out_ready)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic quiet(input int n);
    repeat (n) @(negedge clk);
  endtask

  // called at a negedge; returns at a negedge after the token was taken
  task automatic push_l(input int tag, input int data);
    l_valid = 1'b1; l_tag = TAG_W'(tag); l_data = DATA_W'(data);
    while (!l_ready) @(negedge clk);
    @(negedge clk);
    l_valid = 1'b0;
  endtask

  task automatic push_r(input int tag, input int data);
    r_valid = 1'b1; r_tag = TAG_W'(tag); r_data = DATA_W'(data);
    while (!r_ready) @(negedge clk);
    @(negedge clk);
    r_valid = 1'b0;
  endtask

  task automatic wait_out();
    int t = 0;
    while (!out_valid && t < 50) begin
      @(negedge clk);
      t++;
    end
  endtask

  task automatic pop(input string req, input int tag, input int data);
    wait_out();
    chk(req, "out_valid", 32'(out_valid), 32'd1);
    chk(req, "out_tag", 32'(out_tag), 32'(tag));
    chk(req, "out_data", 32'(out_data), 32'(data));
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic t_reset();
    chk("R8", "out_valid", 32'(out_valid), 32'd0);
    chk("R8", "l_ready", 32'(l_ready), 32'd1);
    chk("R8", "r_ready", 32'(r_ready), 32'd1);
  endtask

  task automatic t_basic_hold();
    logic [TAG_W-1:0]  tg;
    logic [DATA_W-1:0] dt;
    push_l(3, 100);
    push_r(3, 23);
    wait_out();
    chk("R1", "out_tag", 32'(out_tag), 32'd3);
    chk("R1", "out_data", 32'(out_data), 32'd123);
    tg = out_tag; dt = out_data;
    quiet(4);
    chk("R7", "held valid", 32'(out_valid), 32'd1);
    chk("R7", "held tag", 32'(out_tag), 32'(tg));
    chk("R7", "held data", 32'(out_data), 32'(dt));
    pop("R7", 3, 123);
    quiet(3);
    chk("R7", "no duplicate", 32'(out_valid), 32'd0);
    // modulo wrap of the sum
    push_l(11, 16'hFFF0);
    push_r(11, 16'h0020);
    pop("R1", 11, 16'h0010);
  endtask

  task automatic t_mismatch();
    push_l(5, 10);
    push_r(6, 20);
    quiet(6);
    chk("R2", "no fire on unequal tags", 32'(out_valid), 32'd0);
    push_r(5, 7);
    pop("R2", 5, 17);
    push_l(6, 1);
    pop("R2", 6, 21);
  endtask

  task automatic t_out_of_order();
    push_l(1, 40);
    push_l(2, 50);
    push_r(2, 5);
    pop("R5", 2, 55);
    push_r(1, 4);
    pop("R5", 1, 44);
  endtask

  task automatic t_priority();
    push_l(7, 1);
    push_l(8, 2);
    push_l(9, 3);
    push_r(9, 30);
    push_r(8, 20);
    push_r(7, 10);
    quiet(3);
    pop("R6", 9, 33);
    pop("R6", 7, 11);
    pop("R6", 8, 22);
    // two right tokens of one tag: the earlier one pairs first
    push_r(4, 50);
    push_r(4, 60);
    push_l(4, 1);
    pop("R6", 4, 51);
    push_l(4, 2);
    pop("R6", 4, 62);
  endtask

  task automatic t_full();
    for (int i = 0; i < DEPTH; i++) push_l(i, 200 + i);
    chk("R3", "l_ready when full", 32'(l_ready), 32'd0);
    chk("R3", "r_ready unaffected", 32'(r_ready), 32'd1);
    // offered token while full must not be taken
    l_valid = 1'b1; l_tag = 4'd9; l_data = 16'd999;
    quiet(3);
    l_valid = 1'b0;
    push_r(0, 1);
    pop("R3", 0, 201);
    chk("R3", "l_ready after free", 32'(l_ready), 32'd1);
    for (int i = 1; i < DEPTH; i++) begin
      push_r(i, i);
      pop("R3", i, 200 + 2 * i);
    end
    push_r(9, 0);
    quiet(6);
    chk("R3", "stalled token not stored", 32'(out_valid), 32'd0);
    push_l(9, 5);
    pop("R3", 9, 5);
  endtask

  task automatic t_static();
    static_mode = 1'b1;
    quiet(1);
    push_l(2, 5);
    chk("R4", "l_ready with one waiting", 32'(l_ready), 32'd0);
    chk("R4", "r_ready empty edge", 32'(r_ready), 32'd1);
    push_r(2, 6);
    pop("R4", 2, 11);
    chk("R4", "l_ready after fire", 32'(l_ready), 32'd1);
    static_mode = 1'b0;
    quiet(1);
  endtask

  initial begin
    rst_n = 1'b0; static_mode = 1'b0;
    l_valid = 1'b0; l_tag = '0; l_data = '0;
    r_valid = 1'b0; r_tag = '0; r_data = '0;
    out_ready = 1'b0;
    quiet(3);
    rst_n = 1'b1;
    quiet(2);
    t_reset();
    t_basic_hold();
    t_mismatch();
    t_out_of_order();
    t_priority();
    t_full();
    t_static();
    quiet(3);
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule